// File: doc/BRIEF.md
# Load Speculation Dependence Predictor

This block decides whether a load may start ahead of older stores that have not yet committed. It also watches for loads that did so wrongly. A table of two-bit saturating counters, indexed by a folded hash of the load PC, supplies a speculate hint at decode. Once the load's address is known, the load is written into a small load buffer. The buffer records whether the load went ahead speculatively (`spec`) and whether a later store proved that waiting was correct (`update`).

Each committing store searches the buffer for younger loads to the same address. A hit on a speculative load raises an abort one cycle later and names the oldest offending load. It also drives that load's counter to strong no-speculate and frees the aborted entry together with every younger entry. When a load commits, its counter is trained from its `spec` and `update` bits and its slot is released. Re-execution after an abort and the cache access itself are handled elsewhere.

Top module: `ldsp_pred`

## Requirements
- R1: The counter index is the XOR of all `IDX_W`-bit chunks of the load PC, taken from bit 0 upward and zero-padded at the top. With the defaults this is pc[5:0]^pc[11:6]^pc[17:12]^pc[23:18]^pc[29:24]^{4'b0,pc[31:30]}. Counters use 0 = strong no-speculate, 1 = weak no-speculate, 2 = weak speculate and 3 = strong speculate.
- R2: After reset every counter holds 3, the load buffer is empty, `ld_full_o` is 0 and `abort_o` is 0.
- R3: `dec_spec_o` is combinational and is 1 exactly when the counter selected by `dec_pc_i` holds 2 or 3. It reflects every counter write made at earlier clock edges.
- R4: A load is accepted when `ld_valid_i` is high and `ld_full_o` is low. It takes the lowest-numbered free slot, and `ld_slot_o` shows that slot in the same cycle. While all `LB_DEPTH` slots are occupied `ld_full_o` is 1, and a presented load is dropped with no effect on state.
- R5: An accepted load with `ld_older_st_i` = 0 is stored with spec=0 and update=0, and `ld_issue_o` is 1.
- R6: An accepted load with `ld_older_st_i` = 1 and `ld_loadspec_i` = 1 is stored with spec=1 and `ld_issue_o` is 1. With `ld_loadspec_i` = 0 it is stored with spec=0 and `ld_issue_o` is 0.
- R7: A store commit matches a valid entry when the addresses are equal and the load is younger. The load is younger when (load age − store age) mod 2^`AGE_W` is nonzero and its top bit is 0. Loads accepted in the same cycle as the store commit are not searched.
- R8: If any matched entry has spec=1, `abort_o` is 1 in the next cycle. `abort_slot_o` and `abort_age_o` then give the oldest such entry. Its counter is set to 0, and that entry and every valid entry younger than it are freed. Otherwise `abort_o` is 0 in that cycle.
- R9: A matched entry with spec=0 that is not freed by the same commit gets update=1.
- R10: On a load commit the slot `lc_slot_i` is freed and its counter is trained. spec=1 increments it, spec=0 with update=0 increments it, and spec=0 with update=1 sets it to 0. Increments saturate at 3.
- R11: When an abort write and a load-commit training hit the same counter in one cycle, the counter ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_pc_i | input | PC_W | PC of the load being decoded |
| dec_spec_o | output | 1 | Speculate hint for the decoded load |
| ld_valid_i | input | 1 | Load with known address presented for entry |
| ld_pc_i | input | PC_W | PC of the entering load |
| ld_addr_i | input | ADDR_W | Operand address of the entering load |
| ld_age_i | input | AGE_W | Program-order age of the entering load |
| ld_loadspec_i | input | 1 | Hint captured at decode for this load |
| ld_older_st_i | input | 1 | Older uncommitted stores exist |
| ld_issue_o | output | 1 | Load may access the cache now |
| ld_slot_o | output | SLOT_W | Slot given to the entering load |
| ld_full_o | output | 1 | No free slot |
| st_valid_i | input | 1 | Store commit |
| st_addr_i | input | ADDR_W | Address of the committing store |
| st_age_i | input | AGE_W | Age of the committing store |
| lc_valid_i | input | 1 | Load commit |
| lc_slot_i | input | SLOT_W | Slot of the committing load |
| abort_o | output | 1 | Misspeculated load detected |
| abort_slot_o | output | SLOT_W | Slot of the oldest misspeculated load |
| abort_age_o | output | AGE_W | Age of the oldest misspeculated load |

## Verification
Directed sequences first run the three load-entry cases: no older stores, speculative issue and pessimistic wait. These tell apart the `spec` and `update` paths at store commit. Commit training is then driven from all three bit combinations, and the counters are walked up from 0 to saturation. Further patterns cover store and load ages on both sides of the age wrap, several speculative hits on one store (which tells the oldest-selection and younger-flush logic apart from a plain first-match), a full buffer, and a colliding abort and increment on one counter. A long random mix on a small pool of addresses and PCs exercises hash aliasing and interleaved stores and commits. This run is compared every cycle with a behavioural model.

// File: rtl/ldsp_pkg.sv
package ldsp_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_SNS = 2'b00;
  localparam ctr_t CTR_WNS = 2'b01;
  localparam ctr_t CTR_WS  = 2'b10;
  localparam ctr_t CTR_SS  = 2'b11;
endpackage

// File: rtl/ldsp_hash.sv
module ldsp_hash #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 6
) (
  input  logic [PC_W-1:0]  pc_i,
  output logic [IDX_W-1:0] idx_o
);
  localparam int NCH   = (PC_W + IDX_W - 1) / IDX_W;
  localparam int PAD_W = NCH * IDX_W;

  logic [PAD_W-1:0] pad;
  assign pad = PAD_W'(pc_i);

  always_comb begin
    idx_o = '0;
    for (int k = 0; k < NCH; k++) idx_o ^= pad[k*IDX_W +: IDX_W];
  end
endmodule

// File: rtl/ldsp_ctr_table.sv
module ldsp_ctr_table
  import ldsp_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output ctr_t             rd_ctr_o,
  input  logic             abt_force_i,
  input  logic [IDX_W-1:0] abt_idx_i,
  input  logic             trn_valid_i,
  input  logic             trn_inc_i,
  input  logic [IDX_W-1:0] trn_idx_i
);
  localparam int N = 1 << IDX_W;

  ctr_t [N-1:0] ctr_q;

  assign rd_ctr_o = ctr_q[rd_idx_i];

  for (genvar g = 0; g < N; g++) begin : g_ctr
    logic hit_force, hit_inc;
    assign hit_force = (abt_force_i && abt_idx_i == IDX_W'(g)) ||
                       (trn_valid_i && !trn_inc_i && trn_idx_i == IDX_W'(g));
    assign hit_inc   = trn_valid_i && trn_inc_i && trn_idx_i == IDX_W'(g);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              ctr_q[g] <= CTR_SS;
      else if (hit_force)                       ctr_q[g] <= CTR_SNS;  // force beats increment
      else if (hit_inc && ctr_q[g] != CTR_SS)   ctr_q[g] <= ctr_q[g] + 2'd1;
    end
  end
endmodule

// File: rtl/ldsp_ld_buf.sv
module ldsp_ld_buf #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 32,
  parameter int AGE_W  = 6,
  parameter int IDX_W  = 6,
  localparam int SLOT_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  // entry
  input  logic              al_valid_i,
  input  logic [ADDR_W-1:0] al_addr_i,
  input  logic [AGE_W-1:0]  al_age_i,
  input  logic [IDX_W-1:0]  al_hash_i,
  input  logic              al_spec_i,
  output logic              full_o,
  output logic [SLOT_W-1:0] free_slot_o,
  // store search
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [AGE_W-1:0]  st_age_i,
  output logic              abt_hit_o,
  output logic [SLOT_W-1:0] abt_slot_o,
  output logic [AGE_W-1:0]  abt_age_o,
  output logic [IDX_W-1:0]  abt_hash_o,
  // commit
  input  logic              lc_valid_i,
  input  logic [SLOT_W-1:0] lc_slot_i,
  output logic              lc_spec_o,
  output logic              lc_upd_o,
  output logic [IDX_W-1:0]  lc_hash_o
);
  logic [DEPTH-1:0]              vld_q, spec_q, upd_q;
  logic [DEPTH-1:0][ADDR_W-1:0]  addr_q;
  logic [DEPTH-1:0][AGE_W-1:0]   age_q;
  logic [DEPTH-1:0][IDX_W-1:0]   hash_q;

  logic [DEPTH-1:0] match, flush;
  logic             al_fire;

  function automatic logic younger(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
    logic [AGE_W-1:0] d;
    d = a - b;
    return (d != '0) && !d[AGE_W-1];
  endfunction

  // lowest free slot
  always_comb begin
    full_o      = 1'b1;
    free_slot_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld_q[i]) begin
        full_o      = 1'b0;
        free_slot_o = SLOT_W'(i);
      end
    end
  end
  assign al_fire = al_valid_i && !full_o;

  // associative search and oldest speculative hit
  always_comb begin
    abt_hit_o  = 1'b0;
    abt_slot_o = '0;
    abt_age_o  = '0;
    abt_hash_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      match[i] = st_valid_i && vld_q[i] && addr_q[i] == st_addr_i && younger(age_q[i], st_age_i);
      if (match[i] && spec_q[i] && (!abt_hit_o || younger(abt_age_o, age_q[i]))) begin
        abt_hit_o  = 1'b1;
        abt_slot_o = SLOT_W'(i);
        abt_age_o  = age_q[i];
        abt_hash_o = hash_q[i];
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flush
    assign flush[g] = abt_hit_o && vld_q[g] &&
                      (abt_slot_o == SLOT_W'(g) || younger(age_q[g], abt_age_o));
  end

  assign lc_spec_o = spec_q[lc_slot_i];
  assign lc_upd_o  = upd_q[lc_slot_i];
  assign lc_hash_o = hash_q[lc_slot_i];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g]  <= 1'b0;
        spec_q[g] <= 1'b0;
        upd_q[g]  <= 1'b0;
        addr_q[g] <= '0;
        age_q[g]  <= '0;
        hash_q[g] <= '0;
      end else if (al_fire && free_slot_o == SLOT_W'(g)) begin
        vld_q[g]  <= 1'b1;
        spec_q[g] <= al_spec_i;
        upd_q[g]  <= 1'b0;
        addr_q[g] <= al_addr_i;
        age_q[g]  <= al_age_i;
        hash_q[g] <= al_hash_i;
      end else begin
        if (flush[g] || (lc_valid_i && lc_slot_i == SLOT_W'(g))) vld_q[g] <= 1'b0;
        if (match[g] && !spec_q[g]) upd_q[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ldsp_pred.sv
module ldsp_pred
  import ldsp_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int ADDR_W   = 32,
  parameter int AGE_W    = 6,
  parameter int IDX_W    = 6,
  parameter int LB_DEPTH = 8,
  localparam int SLOT_W  = $clog2(LB_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PC_W-1:0]   dec_pc_i,
  output logic              dec_spec_o,
  input  logic              ld_valid_i,
  input  logic [PC_W-1:0]   ld_pc_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [AGE_W-1:0]  ld_age_i,
  input  logic              ld_loadspec_i,
  input  logic              ld_older_st_i,
  output logic              ld_issue_o,
  output logic [SLOT_W-1:0] ld_slot_o,
  output logic              ld_full_o,
  input  logic              st_valid_i,
  input  logic [ADDR_W-1:0] st_addr_i,
  input  logic [AGE_W-1:0]  st_age_i,
  input  logic              lc_valid_i,
  input  logic [SLOT_W-1:0] lc_slot_i,
  output logic              abort_o,
  output logic [SLOT_W-1:0] abort_slot_o,
  output logic [AGE_W-1:0]  abort_age_o
);
  logic [IDX_W-1:0]  dec_idx, ld_idx, abt_hash, lc_hash;
  logic              abt_hit, lc_spec, lc_upd, al_spec;
  logic [SLOT_W-1:0] abt_slot;
  logic [AGE_W-1:0]  abt_age;
  ctr_t              dec_ctr;

  ldsp_hash #(.PC_W(PC_W), .IDX_W(IDX_W)) u_hash_dec (.pc_i(dec_pc_i), .idx_o(dec_idx));
  ldsp_hash #(.PC_W(PC_W), .IDX_W(IDX_W)) u_hash_ld  (.pc_i(ld_pc_i),  .idx_o(ld_idx));

  ldsp_ctr_table #(.IDX_W(IDX_W)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_idx_i    (dec_idx),
    .rd_ctr_o    (dec_ctr),
    .abt_force_i (abt_hit),
    .abt_idx_i   (abt_hash),
    .trn_valid_i (lc_valid_i),
    .trn_inc_i   (lc_spec || !lc_upd),
    .trn_idx_i   (lc_hash)
  );

  assign dec_spec_o = dec_ctr[1];
  assign al_spec    = ld_older_st_i && ld_loadspec_i;

  ldsp_ld_buf #(
    .DEPTH(LB_DEPTH), .ADDR_W(ADDR_W), .AGE_W(AGE_W), .IDX_W(IDX_W)
  ) u_lbuf (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .al_valid_i  (ld_valid_i),
    .al_addr_i   (ld_addr_i),
    .al_age_i    (ld_age_i),
    .al_hash_i   (ld_idx),
    .al_spec_i   (al_spec),
    .full_o      (ld_full_o),
    .free_slot_o (ld_slot_o),
    .st_valid_i  (st_valid_i),
    .st_addr_i   (st_addr_i),
    .st_age_i    (st_age_i),
    .abt_hit_o   (abt_hit),
    .abt_slot_o  (abt_slot),
    .abt_age_o   (abt_age),
    .abt_hash_o  (abt_hash),
    .lc_valid_i  (lc_valid_i),
    .lc_slot_i   (lc_slot_i),
    .lc_spec_o   (lc_spec),
    .lc_upd_o    (lc_upd),
    .lc_hash_o   (lc_hash)
  );

  assign ld_issue_o = ld_valid_i && !ld_full_o && (!ld_older_st_i || ld_loadspec_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      abort_o      <= 1'b0;
      abort_slot_o <= '0;
      abort_age_o  <= '0;
    end else begin
      abort_o      <= abt_hit;
      abort_slot_o <= abt_slot;
      abort_age_o  <= abt_age;
    end
  end
endmodule

// File: rtl/ldsp_pred_chk.sv
module ldsp_pred_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ld_valid_i,
  input logic ld_loadspec_i,
  input logic ld_older_st_i,
  input logic ld_issue_o,
  input logic ld_full_o,
  input logic st_valid_i,
  input logic abort_o
);
  // R8: an abort only follows a store commit
  assert_abort_after_store_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> $past(st_valid_i));

  // R4: nothing issues without an accepted entry
  assert_issue_needs_slot_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_issue_o |-> (ld_valid_i && !ld_full_o));

  // R5: loads with no older stores go at once
  assert_no_older_issues_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && !ld_full_o && !ld_older_st_i) |-> ld_issue_o);

  // R6: pessimistic loads wait
  assert_nospec_waits_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && ld_older_st_i && !ld_loadspec_i) |-> !ld_issue_o);

  // R6: hinted loads with older stores go at once
  assert_spec_issues_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && !ld_full_o && ld_older_st_i && ld_loadspec_i) |-> ld_issue_o);
endmodule

bind ldsp_pred ldsp_pred_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ld_valid_i    (ld_valid_i),
  .ld_loadspec_i (ld_loadspec_i),
  .ld_older_st_i (ld_older_st_i),
  .ld_issue_o    (ld_issue_o),
  .ld_full_o     (ld_full_o),
  .st_valid_i    (st_valid_i),
  .abort_o       (abort_o)
);

// File: tb/ldsp_pred_tb.sv
module ldsp_pred_tb;
  localparam int DEPTH = 8;
  localparam int NCTR  = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] dec_pc_i = '0;
  logic        dec_spec_o;
  logic        ld_valid_i = 1'b0;
  logic [31:0] ld_pc_i = '0;
  logic [31:0] ld_addr_i = '0;
  logic [5:0]  ld_age_i = '0;
  logic        ld_loadspec_i = 1'b0;
  logic        ld_older_st_i = 1'b0;
  logic        ld_issue_o;
  logic [2:0]  ld_slot_o;
  logic        ld_full_o;
  logic        st_valid_i = 1'b0;
  logic [31:0] st_addr_i = '0;
  logic [5:0]  st_age_i = '0;
  logic        lc_valid_i = 1'b0;
  logic [2:0]  lc_slot_i = '0;
  logic        abort_o;
  logic [2:0]  abort_slot_o;
  logic [5:0]  abort_age_o;

  ldsp_pred u_dut (.*);

  always #4 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;

  // reference state
  int mctr[NCTR];
  bit mv[DEPTH], msp[DEPTH], mup[DEPTH];
  int mhs[DEPTH], mag[DEPTH], mad[DEPTH];
  bit mab; int mab_slot, mab_age;
  int last_slot;

  function automatic int hash(logic [31:0] pc);
    int h = 0;
    for (int k = 0; k < 6; k++) h ^= int'((pc >> (6 * k)) & 32'h3f);
    return h;
  endfunction

  function automatic bit younger(int a, int b);
    int d = (a - b) & 63;
    return d != 0 && d < 32;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NCTR; i++) mctr[i] = 3;
    for (int i = 0; i < DEPTH; i++) begin mv[i] = 0; msp[i] = 0; mup[i] = 0; end
    mab = 0; mab_slot = 0; mab_age = 0;
  endtask

  // one clock: check at current inputs, advance model, step the clock
  task automatic cycle();
    bit efull, eiss, mt[DEPTH], nab, tinc;
    int eslot, best, bage, fidx, tidx;
    #1;
    efull = 1; eslot = 0;
    for (int i = DEPTH - 1; i >= 0; i--) if (!mv[i]) begin efull = 0; eslot = i; end
    chk(dec_spec_o == (mctr[hash(dec_pc_i)] >= 2), "R3 decode hint", int'(dec_spec_o), int'(mctr[hash(dec_pc_i)] >= 2));
    chk(ld_full_o == efull, "R4 full flag", int'(ld_full_o), int'(efull));
    if (ld_valid_i && !efull) begin
      chk(int'(ld_slot_o) == eslot, "R4 slot", int'(ld_slot_o), eslot);
      last_slot = eslot;
    end
    eiss = ld_valid_i && !efull && (!ld_older_st_i || ld_loadspec_i);
    chk(ld_issue_o == eiss, ld_older_st_i ? "R6 issue" : "R5 issue", int'(ld_issue_o), int'(eiss));
    chk(abort_o == mab, "R8 abort", int'(abort_o), int'(mab));
    if (mab) begin
      chk(int'(abort_slot_o) == mab_slot, "R8 abort slot", int'(abort_slot_o), mab_slot);
      chk(int'(abort_age_o) == mab_age, "R8 abort age", int'(abort_age_o), mab_age);
    end
    // next state
    best = -1; bage = 0;
    for (int i = 0; i < DEPTH; i++) begin
      mt[i] = st_valid_i && mv[i] && mad[i] == int'(st_addr_i) && younger(mag[i], int'(st_age_i));
      if (mt[i] && msp[i] && (best < 0 || younger(mag[best], mag[i]))) best = i;
    end
    nab = best >= 0;
    if (nab) bage = mag[best];
    fidx = nab ? mhs[best] : -1;
    tidx = -1; tinc = 0;
    if (lc_valid_i) begin tidx = mhs[lc_slot_i]; tinc = msp[lc_slot_i] || !mup[lc_slot_i]; end
    if (tidx >= 0) begin
      if (!tinc) mctr[tidx] = 0;
      else if (tidx != fidx && mctr[tidx] < 3) mctr[tidx]++;
    end
    if (fidx >= 0) mctr[fidx] = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (mt[i] && !msp[i]) mup[i] = 1;
      if (nab && mv[i] && (i == best || younger(mag[i], bage))) mv[i] = 0;
      if (lc_valid_i && int'(lc_slot_i) == i) mv[i] = 0;
    end
    if (ld_valid_i && !efull) begin
      mv[eslot] = 1; msp[eslot] = ld_older_st_i && ld_loadspec_i; mup[eslot] = 0;
      mhs[eslot] = hash(ld_pc_i); mag[eslot] = int'(ld_age_i); mad[eslot] = int'(ld_addr_i);
    end
    mab = nab; if (nab) begin mab_slot = best; mab_age = bage; end
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic clr();
    ld_valid_i = 0; st_valid_i = 0; lc_valid_i = 0;
  endtask

  task automatic do_ld(logic [31:0] pc, logic [31:0] a, int age, bit ls, bit old);
    ld_valid_i = 1; ld_pc_i = pc; ld_addr_i = a; ld_age_i = 6'(age);
    ld_loadspec_i = ls; ld_older_st_i = old;
    cycle(); clr();
  endtask

  task automatic do_st(logic [31:0] a, int age);
    st_valid_i = 1; st_addr_i = a; st_age_i = 6'(age);
    cycle(); clr();
  endtask

  task automatic do_lc(int slot);
    lc_valid_i = 1; lc_slot_i = 3'(slot);
    cycle(); clr();
  endtask

  task automatic probe(logic [31:0] pc, bit exp, string tag);
    dec_pc_i = pc; #1;
    chk(dec_spec_o == exp, tag, int'(dec_spec_o), int'(exp));
    cycle();
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog R2 actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int sa, sb, sc, sx, sy, seq;
    model_reset();
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    // R2: reset state
    chk(abort_o == 0, "R2 abort after reset", int'(abort_o), 0);
    chk(ld_full_o == 0, "R2 empty after reset", int'(ld_full_o), 0);
    for (int k = 0; k < 6; k++) probe(32'h1000 * k + 32'h44 * k, 1'b1, "R2 counter resets to 3");

    // R5/R6: three entry kinds; R7-R9: one store hits spec and non-spec loads
    do_ld(32'h120, 32'h40, 5, 1, 0); sa = last_slot;
    do_ld(32'h240, 32'h80, 7, 1, 1); sb = last_slot;
    do_ld(32'h360, 32'h80, 6, 0, 1); sc = last_slot;
    do_st(32'h80, 4);
    chk(abort_o == 1 && int'(abort_slot_o) == sb, "R8 abort names spec load", int'(abort_slot_o), sb);
    probe(32'h240, 1'b0, "R8 aborted counter forced to 0");
    do_lc(sc);                                   // R9 update=1 -> R10 force
    probe(32'h360, 1'b0, "R10 update bit trains to 0");
    do_lc(sa);
    probe(32'h120, 1'b1, "R10 saturate at 3");
    // R10: walk counter 0 -> 1 -> 2
    do_ld(32'h240, 32'h90, 8, 0, 0); do_lc(last_slot);
    probe(32'h240, 1'b0, "R10 counter at 1");
    do_ld(32'h240, 32'h90, 9, 0, 0); do_lc(last_slot);
    probe(32'h240, 1'b1, "R3 counter at 2 predicts speculate");

    // R7: age wrap
    do_ld(32'h480, 32'h10, 1, 1, 1); sa = last_slot;
    do_st(32'h10, 2);
    chk(abort_o == 0, "R7 older load not matched", int'(abort_o), 0);
    do_st(32'h10, 62);
    chk(abort_o == 1, "R7 match across age wrap", int'(abort_o), 1);

    // R8: oldest of several hits, younger entries flushed
    do_ld(32'h500, 32'h20, 12, 1, 1);
    do_ld(32'h504, 32'h20, 10, 1, 1); sx = last_slot;
    do_ld(32'h508, 32'h20, 11, 1, 1);
    do_ld(32'h50c, 32'h24, 13, 0, 0);
    do_st(32'h20, 9);
    chk(int'(abort_age_o) == 10 && int'(abort_slot_o) == sx, "R8 oldest selected", int'(abort_age_o), 10);
    chk(ld_full_o == 0, "R8 flush frees slots", int'(ld_full_o), 0);

    // R4: fill and overflow
    for (int k = 0; k < DEPTH; k++) do_ld(32'h600 + 4 * k, 32'h100, 20 + k, 0, 0);
    chk(ld_full_o == 1, "R4 full after depth loads", int'(ld_full_o), 1);
    do_ld(32'h700, 32'h100, 30, 1, 0);
    for (int k = 0; k < DEPTH; k++) do_lc(k);

    // R11: same counter forced and incremented (0x000 and 0x041 share a hash)
    do_ld(32'h000, 32'h200, 40, 0, 0); sx = last_slot;
    do_ld(32'h041, 32'h300, 41, 1, 1); sy = last_slot;
    st_valid_i = 1; st_addr_i = 32'h300; st_age_i = 6'd39;
    lc_valid_i = 1; lc_slot_i = 3'(sx);
    cycle(); clr();
    probe(32'h000, 1'b0, "R11 force wins over increment");
    probe(32'h041, 1'b0, "R1 aliased PC shares counter");

    // random mix, model compared every cycle
    seq = 0;
    for (int n = 0; n < 3000; n++) begin
      int pick, nv;
      dec_pc_i = 32'h40 * ($urandom_range(0, 11)) + 32'h1000 * $urandom_range(0, 1);
      if ($urandom_range(0, 2) != 0) begin
        ld_valid_i = 1;
        ld_pc_i = 32'h40 * ($urandom_range(0, 11)) + 32'h1000 * $urandom_range(0, 1);
        ld_addr_i = 32'h8 * $urandom_range(0, 3);
        ld_age_i = 6'(seq); seq++;
        ld_loadspec_i = 1'($urandom_range(0, 1));
        ld_older_st_i = 1'($urandom_range(0, 1));
      end
      nv = 0;
      for (int i = 0; i < DEPTH; i++) nv += mv[i];
      if ($urandom_range(0, 3) == 0) begin
        st_valid_i = 1; st_addr_i = 32'h8 * $urandom_range(0, 3);
        st_age_i = 6'(seq - int'($urandom_range(1, 10)));
      end else if (nv > 0 && $urandom_range(0, 2) != 0) begin
        pick = $urandom_range(0, DEPTH - 1);
        while (!mv[pick]) pick = (pick + 1) % DEPTH;
        lc_valid_i = 1; lc_slot_i = 3'(pick);
      end
      cycle(); clr();
    end
    cycle();

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule